// File: doc/BRIEF.md
# Mirrored-Bank Parity-Fallback Memory

This block is a synchronous word memory made of byte lanes. Each lane is nine bits wide, and its top bit is a parity bit that the writer supplies. The block has two operating modes, selected by a static mode input.

In mirrored mode (mode 0) the storage holds half as many words. Every write lands in two banks, called primary and secondary. On a read, each primary lane is checked on its own for odd parity. A lane that passes is returned. A lane that fails is swapped for the same lane of the secondary copy, and a per-lane flag reports the swap. The secondary copy itself is never checked. In plain mode (mode 1) the same storage is one array of twice the depth, and the top address bit picks the half.

Writes pass through a one-deep pending stage before they reach the arrays. A read that hits a pending write is served from that stage, and those lanes are not parity-checked. Changing the mode needs quiet cycles on both sides of the change. Accesses inside the settling window are refused and raise an error flag. A test-only port flips chosen bits in a row of the primary bank, which lets the fallback path be exercised.

Top module: `mbp_mirror_mem`

## Requirements
- R1: In mode 0 a write is stored in both banks at row `addr[AW-2:0]`, and `addr[AW-1]` is ignored for both reads and writes.
- R2: An accepted read drives `rd_data`, `lane_fix` and `rd_valid` high in the following cycle. `rd_valid` is low in every cycle that does not follow an accepted read.
- R3: In mode 0, a primary lane whose nine bits hold an odd number of ones is returned as stored, with its `lane_fix` bit at 0.
- R4: In mode 0, a primary lane whose nine bits hold an even number of ones is replaced by the secondary lane, and its `lane_fix` bit is 1. Bit i of `lane_fix` and lane i (`data[9i+8:9i]`) are decided independently of the other lanes.
- R5: Secondary data is never checked. If both copies of a lane have even parity, the secondary lane is returned unchanged and the flag is 1.
- R6: A write is held for one cycle in a pending stage and reaches the arrays at the end of the next cycle. A read of the same word in that next cycle returns the pending lanes without a parity check, with flag 0 for those lanes. The lanes the write did not enable come from the arrays.
- R7: A write updates only the lanes whose `byte_en[i]` is 1, where lane i is `wr_data[9i+8:9i]`.
- R8: In mode 1 the memory holds 2^AW words. `addr[AW-1]`=0 selects the primary bank row and 1 selects the secondary bank row. No parity check is done, and `lane_fix` stays 0.
- R9: When `mode` changes in cycle c, every read or write presented in cycle c or in the following SETTLE cycles is discarded, and `access_err` is 1 in the cycle after each such attempt.
- R10: If `mode` changes in a cycle that follows an accepted access by one or two cycles, `access_err` is 1 in the next cycle.
- R11: After reset, `rd_valid`, `access_err`, `lane_fix` and `rd_data` are all 0.
- R12: `inj_en` XORs `inj_mask` into primary-bank row `inj_row` at the clock edge. The secondary bank is left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 0 = mirrored half-capacity, 1 = plain full-capacity |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | AW | Word address |
| byte_en | input | LANES | Per-lane write enable |
| wr_data | input | 9*LANES | Write data, parity in the top bit of each lane |
| inj_en | input | 1 | Test backdoor: flip bits in the primary bank |
| inj_row | input | AW-1 | Row for the injection |
| inj_mask | input | 9*LANES | Bits to flip |
| rd_data | output | 9*LANES | Read data |
| rd_valid | output | 1 | Read data valid |
| lane_fix | output | LANES | Lane taken from the secondary copy |
| access_err | output | 1 | Access refused, or mode changed too soon after an access |

## Verification
The bench corrupts one primary lane and then both lanes. A design that checked parity per word rather than per lane would flag the wrong lanes. It stores data with even parity in both copies: a design that checked the secondary copy would not return it unchanged. It reads a word in the cycle right after writing it, deliberately with bad parity. A design without forwarding would return stale data, and one that checked forwarded lanes would raise a false flag. The bench also switches modes and probes inside the settling window, including a write that must leave no trace. It reads rows written in plain mode back in mirrored mode, which exposes wrong bank decoding.

// File: rtl/mbp_pkg.sv
package mbp_pkg;
  localparam int LANE_W = 9;

  // Odd number of ones across the nine lane bits means the primary copy is trusted
  function automatic logic lane_odd(input logic [LANE_W-1:0] lane);
    return ^lane;
  endfunction

  // Banks touched by a write: bit0 primary, bit1 secondary
  function automatic logic [1:0] bank_mask(input logic plain, input logic top);
    if (!plain) return 2'b11;
    return top ? 2'b10 : 2'b01;
  endfunction
endpackage

// File: rtl/mbp_mode_guard.sv
module mbp_mode_guard #(
  parameter int SETTLE = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode,
  input  logic rd_en,
  input  logic wr_en,
  output logic acc_blocked,
  output logic mode_chg,
  output logic access_err
);
  localparam int CW = $clog2(SETTLE + 1);

  logic          mode_q;
  logic [CW-1:0] settle_cnt;
  logic [1:0]    acc_hist;
  logic          attempt;

  assign mode_chg    = (mode != mode_q);
  assign acc_blocked = mode_chg || (settle_cnt != '0);
  assign attempt     = rd_en || wr_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= mode;
      settle_cnt <= '0;
      acc_hist   <= '0;
      access_err <= 1'b0;
    end else begin
      mode_q <= mode;
      if (mode_chg)              settle_cnt <= CW'(SETTLE);
      else if (settle_cnt != '0) settle_cnt <= settle_cnt - 1'b1;
      acc_hist   <= {acc_hist[0], attempt && !acc_blocked};
      access_err <= (acc_blocked && attempt) || (mode_chg && (acc_hist != 2'b00));
    end
  end
endmodule

// File: rtl/mbp_write_stage.sv
module mbp_write_stage
  import mbp_pkg::*;
#(
  parameter int RW    = 5,
  parameter int LANES = 2,
  localparam int W    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_accept,
  input  logic             mode,
  input  logic             top,
  input  logic [RW-1:0]    row,
  input  logic [LANES-1:0] byte_en,
  input  logic [W-1:0]     wr_data,
  output logic             pend_valid,
  output logic [RW-1:0]    pend_row,
  output logic [1:0]       pend_mask,
  output logic [LANES-1:0] pend_be,
  output logic [W-1:0]     pend_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_row   <= '0;
      pend_mask  <= '0;
      pend_be    <= '0;
      pend_data  <= '0;
    end else begin
      pend_valid <= wr_accept;
      if (wr_accept) begin
        pend_row  <= row;
        pend_mask <= bank_mask(mode, top);
        pend_be   <= byte_en;
        pend_data <= wr_data;
      end
    end
  end
endmodule

// File: rtl/mbp_bank_store.sv
module mbp_bank_store
  import mbp_pkg::*;
#(
  parameter int RW    = 5,
  parameter int LANES = 2,
  localparam int W    = LANES * LANE_W,
  localparam int DEPTH = 1 << RW
) (
  input  logic             clk,
  input  logic             commit,
  input  logic [RW-1:0]    commit_row,
  input  logic [1:0]       commit_mask,
  input  logic [LANES-1:0] commit_be,
  input  logic [W-1:0]     commit_data,
  input  logic             inj_en,
  input  logic [RW-1:0]    inj_row,
  input  logic [W-1:0]     inj_mask,
  input  logic [RW-1:0]    rd_row,
  output logic [W-1:0]     prim_word,
  output logic [W-1:0]     sec_word
);
  logic [W-1:0] bank_p [DEPTH];
  logic [W-1:0] bank_s [DEPTH];

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int l = 0; l < LANES; l++) begin
        if (commit_be[l]) begin
          if (commit_mask[0]) bank_p[commit_row][l*LANE_W +: LANE_W] <= commit_data[l*LANE_W +: LANE_W];
          if (commit_mask[1]) bank_s[commit_row][l*LANE_W +: LANE_W] <= commit_data[l*LANE_W +: LANE_W];
        end
      end
    end
    if (inj_en) bank_p[inj_row] <= bank_p[inj_row] ^ inj_mask;
  end

  assign prim_word = bank_p[rd_row];
  assign sec_word  = bank_s[rd_row];
endmodule

// File: rtl/mbp_read_select.sv
module mbp_read_select
  import mbp_pkg::*;
#(
  parameter int LANES = 2,
  localparam int W    = LANES * LANE_W
) (
  input  logic             mode,
  input  logic             top,
  input  logic [W-1:0]     prim_word,
  input  logic [W-1:0]     sec_word,
  input  logic             pend_hit,
  input  logic [LANES-1:0] pend_be,
  input  logic [W-1:0]     pend_data,
  output logic [W-1:0]     sel_data,
  output logic [LANES-1:0] sel_fix
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] p_lane, s_lane, w_lane;
    assign p_lane = prim_word[l*LANE_W +: LANE_W];
    assign s_lane = sec_word[l*LANE_W +: LANE_W];
    assign w_lane = pend_data[l*LANE_W +: LANE_W];

    always_comb begin
      sel_fix[l] = 1'b0;
      if (pend_hit && pend_be[l]) begin
        sel_data[l*LANE_W +: LANE_W] = w_lane;
      end else if (mode) begin
        sel_data[l*LANE_W +: LANE_W] = top ? s_lane : p_lane;
      end else if (lane_odd(p_lane)) begin
        sel_data[l*LANE_W +: LANE_W] = p_lane;
      end else begin
        sel_data[l*LANE_W +: LANE_W] = s_lane;
        sel_fix[l] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mbp_mirror_mem.sv
module mbp_mirror_mem
  import mbp_pkg::*;
#(
  parameter int AW     = 6,
  parameter int LANES  = 2,
  parameter int SETTLE = 32,
  localparam int W     = LANES * LANE_W,
  localparam int RW    = AW - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] byte_en,
  input  logic [W-1:0]     wr_data,
  input  logic             inj_en,
  input  logic [RW-1:0]    inj_row,
  input  logic [W-1:0]     inj_mask,
  output logic [W-1:0]     rd_data,
  output logic             rd_valid,
  output logic [LANES-1:0] lane_fix,
  output logic             access_err
);
  logic             acc_blocked, mode_chg, rd_accept, wr_accept, pend_hit;
  logic [RW-1:0]    row;
  logic             top;
  logic             pend_valid;
  logic [RW-1:0]    pend_row;
  logic [1:0]       pend_mask;
  logic [LANES-1:0] pend_be;
  logic [W-1:0]     pend_data;
  logic [W-1:0]     prim_word, sec_word, sel_data;
  logic [LANES-1:0] sel_fix;

  assign row       = addr[RW-1:0];
  assign top       = addr[AW-1];
  assign rd_accept = rd_en && !acc_blocked;
  assign wr_accept = wr_en && !acc_blocked;
  assign pend_hit  = pend_valid && (pend_row == row) && pend_mask[mode ? top : 1'b0];

  mbp_mode_guard #(.SETTLE(SETTLE)) u_guard (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rd_en(rd_en), .wr_en(wr_en),
    .acc_blocked(acc_blocked), .mode_chg(mode_chg), .access_err(access_err)
  );

  mbp_write_stage #(.RW(RW), .LANES(LANES)) u_wstage (
    .clk(clk), .rst_n(rst_n), .wr_accept(wr_accept), .mode(mode), .top(top),
    .row(row), .byte_en(byte_en), .wr_data(wr_data),
    .pend_valid(pend_valid), .pend_row(pend_row), .pend_mask(pend_mask),
    .pend_be(pend_be), .pend_data(pend_data)
  );

  mbp_bank_store #(.RW(RW), .LANES(LANES)) u_store (
    .clk(clk), .commit(pend_valid), .commit_row(pend_row), .commit_mask(pend_mask),
    .commit_be(pend_be), .commit_data(pend_data),
    .inj_en(inj_en), .inj_row(inj_row), .inj_mask(inj_mask),
    .rd_row(row), .prim_word(prim_word), .sec_word(sec_word)
  );

  mbp_read_select #(.LANES(LANES)) u_rsel (
    .mode(mode), .top(top), .prim_word(prim_word), .sec_word(sec_word),
    .pend_hit(pend_hit), .pend_be(pend_be), .pend_data(pend_data),
    .sel_data(sel_data), .sel_fix(sel_fix)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      lane_fix <= '0;
    end else begin
      rd_valid <= rd_accept;
      if (rd_accept) begin
        rd_data  <= sel_data;
        lane_fix <= sel_fix;
      end else begin
        lane_fix <= '0;
      end
    end
  end
endmodule

// File: rtl/mbp_mirror_mem_chk.sv
module mbp_mirror_mem_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode,
  input logic             rd_en,
  input logic             wr_en,
  input logic             rd_valid,
  input logic [LANES-1:0] lane_fix,
  input logic             access_err,
  input logic             acc_blocked,
  input logic             mode_chg,
  input logic             rd_accept,
  input logic             wr_accept,
  input logic             pend_valid
);
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) rd_accept |=> rd_valid); // R2
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n) !rd_accept |=> !rd_valid); // R2
  AST_FIX_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) (lane_fix != '0) |-> rd_valid); // R4
  AST_PLAIN_NO_FIX: assert property (@(posedge clk) disable iff (!rst_n) (rd_valid && $past(mode)) |-> (lane_fix == '0)); // R8
  AST_PEND_FILL: assert property (@(posedge clk) disable iff (!rst_n) wr_accept |=> pend_valid); // R6
  AST_PEND_ONE_DEEP: assert property (@(posedge clk) disable iff (!rst_n) !wr_accept |=> !pend_valid); // R6
  AST_SETTLE_START: assert property (@(posedge clk) disable iff (!rst_n) mode_chg |=> acc_blocked); // R9
  AST_BLOCKED_READ: assert property (@(posedge clk) disable iff (!rst_n) (acc_blocked && rd_en) |=> (!rd_valid && access_err)); // R9
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) access_err |-> $past(rd_en || wr_en || mode_chg)); // R10
endmodule

bind mbp_mirror_mem mbp_mirror_mem_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .rd_en(rd_en), .wr_en(wr_en),
  .rd_valid(rd_valid), .lane_fix(lane_fix), .access_err(access_err),
  .acc_blocked(acc_blocked), .mode_chg(mode_chg), .rd_accept(rd_accept),
  .wr_accept(wr_accept), .pend_valid(pend_valid)
);

// File: tb/sim_mbp_mirror_mem.sv
`timescale 1ns/1ps
module sim_mbp_mirror_mem;
  localparam int AW = 6, LANES = 2, W = 18;

  logic clk = 1'b0, rst_n = 1'b0, mode = 1'b0, rd_en = 1'b0, wr_en = 1'b0, inj_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [LANES-1:0] byte_en = '0;
  logic [W-1:0] wr_data = '0, inj_mask = '0;
  logic [AW-2:0] inj_row = '0;
  logic [W-1:0] rd_data;
  logic rd_valid, access_err;
  logic [LANES-1:0] lane_fix;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mbp_mirror_mem #(.AW(AW), .LANES(LANES), .SETTLE(32)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .byte_en(byte_en), .wr_data(wr_data), .inj_en(inj_en), .inj_row(inj_row),
    .inj_mask(inj_mask), .rd_data(rd_data), .rd_valid(rd_valid), .lane_fix(lane_fix),
    .access_err(access_err)
  );

  function automatic logic [8:0] mk(input logic [7:0] b);
    return {~^b, b};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [1:0] be, input logic [W-1:0] d);
    addr = a; byte_en = be; wr_data = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d, output logic [1:0] f, output logic v);
    addr = a; rd_en = 1'b1;
    tick();
    rd_en = 1'b0; d = rd_data; f = lane_fix; v = rd_valid;
  endtask

  task automatic inject(input logic [AW-2:0] r, input logic [W-1:0] m);
    inj_row = r; inj_mask = m; inj_en = 1'b1;
    tick();
    inj_en = 1'b0;
  endtask

  logic [W-1:0] d; logic [1:0] f; logic v;

  task automatic t_reset();
    check("R11 rd_valid", rd_valid, 0);
    check("R11 access_err", access_err, 0);
    check("R11 lane_fix", lane_fix, 0);
    check("R11 rd_data", rd_data, 0);
  endtask

  task automatic t_basic();
    logic [W-1:0] g = {mk(8'h3C), mk(8'hA5)};
    wr(6'd5, 2'b11, g); idle(2);
    rd(6'd5, d, f, v);
    check("R1 R3 data", d, g); check("R3 fix", f, 2'b00); check("R2 valid", v, 1);
    idle(1); check("R2 valid drops", rd_valid, 0);
    rd(6'd37, d, f, v);
    check("R1 top bit ignored", d, g);
  endtask

  task automatic t_fallback();
    logic [W-1:0] g = {mk(8'h3C), mk(8'hA5)};
    inject(5'd5, 18'h00001); idle(1);
    rd(6'd5, d, f, v);
    check("R4 R12 lane0 from secondary", d, g); check("R4 single lane fix", f, 2'b01);
    inject(5'd5, 18'h00200); idle(1);
    rd(6'd5, d, f, v);
    check("R4 both lanes data", d, g); check("R4 both lanes fix", f, 2'b11);
  endtask

  task automatic t_sec_unchecked();
    logic [W-1:0] e = {9'h0FF, 9'h003};
    wr(6'd9, 2'b11, e); idle(2);
    rd(6'd9, d, f, v);
    check("R5 raw secondary", d, e); check("R5 fix", f, 2'b11);
  endtask

  task automatic t_forward();
    logic [W-1:0] g = {mk(8'h11), mk(8'h22)};
    wr(6'd12, 2'b11, g); idle(2);
    addr = 6'd12; byte_en = 2'b01; wr_data = {9'h000, 9'h003}; wr_en = 1'b1;
    tick();
    wr_en = 1'b0; rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
    check("R6 forwarded data", rd_data, {mk(8'h11), 9'h003});
    check("R6 forwarded no check", lane_fix, 2'b00);
    idle(1);
    rd(6'd12, d, f, v);
    check("R6 committed even lane", f, 2'b01);
  endtask

  task automatic t_byte_en();
    wr(6'd20, 2'b11, {mk(8'h44), mk(8'h77)});
    wr(6'd20, 2'b10, {mk(8'h99), mk(8'hEE)}); idle(2);
    rd(6'd20, d, f, v);
    check("R7 partial write", d, {mk(8'h99), mk(8'h77)});
  endtask

  task automatic t_mode_plain();
    logic [W-1:0] y = {mk(8'h66), mk(8'h55)};
    idle(3);
    mode = 1'b1; tick();
    rd(6'd5, d, f, v);
    check("R9 blocked read valid", v, 0); check("R9 blocked read err", access_err, 1);
    wr(6'd20, 2'b11, 18'h0);
    check("R9 blocked write err", access_err, 1);
    idle(35);
    check("R9 err clears", access_err, 0);
    wr(6'd33, 2'b11, {9'h0FF, 9'h0FF});
    wr(6'd1, 2'b11, y); idle(2);
    rd(6'd33, d, f, v);
    check("R8 upper half", d, {9'h0FF, 9'h0FF}); check("R8 no fix", f, 2'b00);
    rd(6'd1, d, f, v);
    check("R8 lower half", d, y);
    rd(6'd20, d, f, v);
    check("R9 blocked write no effect", d, {mk(8'h99), mk(8'h77)});
    rd(6'd52, d, f, v);
    check("R8 R1 mirror copy", d, {mk(8'h99), mk(8'h77)});
  endtask

  task automatic t_early_change();
    logic [W-1:0] y = {mk(8'h66), mk(8'h55)};
    idle(3);
    addr = 6'd2; byte_en = 2'b11; wr_data = y; wr_en = 1'b1;
    tick();
    wr_en = 1'b0; mode = 1'b0;
    tick();
    check("R10 early change err", access_err, 1);
    idle(35);
    rd(6'd1, d, f, v);
    check("R3 cross mode primary", d, y); check("R3 cross mode fix", f, 2'b00);
    inject(5'd1, 18'h00010); idle(1);
    rd(6'd1, d, f, v);
    check("R4 cross mode lane0", d, {mk(8'h66), 9'h0FF}); check("R4 cross mode fix", f, 2'b01);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_basic();
    t_fallback();
    t_sec_unchecked();
    t_forward();
    t_byte_en();
    t_mode_plain();
    t_early_change();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule